// File: doc/BRIEF.md
# Ring Station Router

This block is one stop on a one-way ring that lets many logical channels share a single physical path. Every channel is known on the ring by a small numeric tag. Each station holds a routing table that is fixed when the design is built. For each local sender, the table gives the tag it stamps on its words. For each local receiver, it gives the tag the receiver listens for.

A word coming in from upstream is checked against the receiver table. On a match, the payload goes into that receiver's queue. With no match, the whole word goes on unchanged through a one-entry stage register to the next station. Local senders write into small queues that have a push/full interface. Receivers read from queues that have a pop/not-empty interface. Seen from the endpoints, the path therefore looks like a plain point-to-point queue, wherever the partner endpoint sits on the ring.

Traffic already on the ring always takes the stage before local traffic. A receiver that is full stalls the ring input without losing the word.

Top module: `ring_station`

## Requirements
- R1: After reset, `ring_out_valid` is 0, every `rx_not_empty` bit is 0, every `tx_full` bit is 0 and `ring_in_ready` is 1.
- R2: A ring word whose tag matches no receiver entry is accepted when the stage is free. It appears on `ring_out_data` unchanged after the next rising edge.
- R3: A ring word whose tag equals receiver entry k has its payload pushed into receiver queue k. It is visible on `rx_first` slice k after the next edge, and words leave that queue in arrival order.
- R4: A word is ID_W + PAY_W bits wide, with the tag in the top ID_W bits and the payload in the low PAY_W bits. Routing entries are packed so that entry k sits at bits [k*ID_W +: ID_W].
- R5: A word pushed into sender queue k leaves on `ring_out_data` tagged with sender entry k. It appears two edges after the push when nothing competes with it.
- R6: When an unmatched ring word and a local word both want a free stage, the ring word is loaded first and the local word follows on a later cycle.
- R7: When the receiver named by the incoming tag is full, `ring_in_ready` is 0 and the word is held upstream. Local senders may still use the free stage in that time.
- R8: While `ring_out_valid` is 1 and `ring_out_ready` is 0, the output word stays valid and unchanged, and unmatched ring input is not accepted.
- R9: When several sender queues hold words, the lowest-numbered queue is served first.
- R10: `tx_full[k]` is 1 when sender queue k holds TX_DEPTH words, and a push made while it is full is dropped.
- R11: A pop on an empty receiver queue is ignored and does not disturb later deliveries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_in_valid | input | 1 | Upstream word present |
| ring_in_data | input | ID_W+PAY_W | Upstream word, tag in top bits |
| ring_in_ready | output | 1 | Station takes the upstream word this cycle |
| ring_out_valid | output | 1 | Stage register holds a word for downstream |
| ring_out_data | output | ID_W+PAY_W | Word sent downstream |
| ring_out_ready | input | 1 | Downstream takes the stage word |
| tx_enq | input | N_TX | Push strobe per local sender |
| tx_data | input | N_TX*PAY_W | Payload per local sender, sender k at [k*PAY_W +: PAY_W] |
| tx_full | output | N_TX | Sender queue full |
| rx_deq | input | N_RX | Pop strobe per local receiver |
| rx_first | output | N_RX*PAY_W | Head payload per local receiver |
| rx_not_empty | output | N_RX | Receiver queue holds data |

## Verification
The hardest state to reach from the ports is a held ring word, stuck because its own receiver is full, while a local sender fills the free stage and the receiver is then drained by one entry. The bench gets there by sending two words for one receiver without popping. It offers a third, pushes a local word in the same cycle, and then pops once. It then checks that the held word enters only after the pop and that all three payloads come out in order. A full sweep over every tag value and several payloads checks the consume-or-forward decision against a table the bench restates itself.

// File: rtl/ring_stn_pkg.sv
package ring_stn_pkg;
  typedef enum logic [1:0] {
    STG_IDLE  = 2'd0,
    STG_RING  = 2'd1,
    STG_LOCAL = 2'd2
  } stage_src_e;
endpackage

// File: rtl/station_fifo.sv
module station_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      if (do_push && !do_pop)      count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/station_lookup.sv
module station_lookup #(
  parameter int ID_W  = 3,
  parameter int N_ENT = 2,
  parameter logic [N_ENT*ID_W-1:0] TABLE = '0,
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [ID_W-1:0] id,
  output logic            hit,
  output logic [IW-1:0]   idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (TABLE[e*ID_W +: ID_W] == id) begin
        hit = 1'b1;
        idx = IW'(e);
      end
    end
  end
endmodule

// File: rtl/station_inject.sv
module station_inject #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  function automatic logic [N-1:0] lowest_set(input logic [N-1:0] v);
    return v & (~v + N'(1));
  endfunction

  assign grant = lowest_set(req);
  assign any   = |req;
endmodule

// File: rtl/ring_station.sv
module ring_station
  import ring_stn_pkg::*;
#(
  parameter int ID_W     = 3,
  parameter int PAY_W    = 8,
  parameter int N_TX     = 2,
  parameter int N_RX     = 2,
  parameter int TX_DEPTH = 2,
  parameter int RX_DEPTH = 2,
  parameter logic [N_TX*ID_W-1:0] TX_IDS = {3'd6, 3'd1},
  parameter logic [N_RX*ID_W-1:0] RX_IDS = {3'd3, 3'd5},
  localparam int MSG_W = ID_W + PAY_W,
  localparam int RXI_W = (N_RX > 1) ? $clog2(N_RX) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ring_in_valid,
  input  logic [MSG_W-1:0]      ring_in_data,
  output logic                  ring_in_ready,
  output logic                  ring_out_valid,
  output logic [MSG_W-1:0]      ring_out_data,
  input  logic                  ring_out_ready,
  input  logic [N_TX-1:0]       tx_enq,
  input  logic [N_TX*PAY_W-1:0] tx_data,
  output logic [N_TX-1:0]       tx_full,
  input  logic [N_RX-1:0]       rx_deq,
  output logic [N_RX*PAY_W-1:0] rx_first,
  output logic [N_RX-1:0]       rx_not_empty
);
  // Named internal events, brought out for the checker.
  logic [ID_W-1:0]  in_id;
  logic [PAY_W-1:0] in_pay;
  logic             hit;
  logic [RXI_W-1:0] hit_idx;
  logic [N_RX-1:0]  rx_full;
  logic [N_RX-1:0]  rx_empty;
  logic             rx_full_sel;
  logic             fwd_req;
  logic             stage_free;
  logic             fwd_take;
  logic             deliver_take;
  logic             local_take;
  logic [N_TX-1:0]  tx_empty;
  logic [N_TX-1:0]  tx_grant;
  logic             tx_any;
  logic [MSG_W-1:0] tx_word [N_TX];
  logic [MSG_W-1:0] local_word;
  stage_src_e       stage_src;

  logic             stg_v;
  logic [MSG_W-1:0] stg_d;

  function automatic logic [ID_W-1:0] tag_of(input logic [MSG_W-1:0] w);
    return w[MSG_W-1 -: ID_W];
  endfunction

  function automatic logic [PAY_W-1:0] payload_of(input logic [MSG_W-1:0] w);
    return w[PAY_W-1:0];
  endfunction

  assign in_id  = tag_of(ring_in_data);
  assign in_pay = payload_of(ring_in_data);

  station_lookup #(
    .ID_W (ID_W),
    .N_ENT(N_RX),
    .TABLE(RX_IDS)
  ) u_lookup (
    .id (in_id),
    .hit(hit),
    .idx(hit_idx)
  );

  assign stage_free   = !stg_v || ring_out_ready;
  assign rx_full_sel  = rx_full[hit_idx];
  assign fwd_req      = ring_in_valid && !hit;
  assign fwd_take     = fwd_req && stage_free;
  assign deliver_take = ring_in_valid && hit && !rx_full_sel;
  assign ring_in_ready = hit ? !rx_full_sel : stage_free;

  // Local receivers.
  generate
    for (genvar r = 0; r < N_RX; r++) begin : g_rx
      logic rx_push;
      assign rx_push = deliver_take && (hit_idx == RXI_W'(r));
      station_fifo #(
        .W    (PAY_W),
        .DEPTH(RX_DEPTH)
      ) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rx_push),
        .push_data(in_pay),
        .pop      (rx_deq[r]),
        .head     (rx_first[r*PAY_W +: PAY_W]),
        .full     (rx_full[r]),
        .empty    (rx_empty[r])
      );
      assign rx_not_empty[r] = !rx_empty[r];
    end
  endgenerate

  // Local senders.
  generate
    for (genvar t = 0; t < N_TX; t++) begin : g_tx
      logic [PAY_W-1:0] tx_head;
      logic             tx_pop;
      assign tx_pop = local_take && tx_grant[t];
      station_fifo #(
        .W    (PAY_W),
        .DEPTH(TX_DEPTH)
      ) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (tx_enq[t]),
        .push_data(tx_data[t*PAY_W +: PAY_W]),
        .pop      (tx_pop),
        .head     (tx_head),
        .full     (tx_full[t]),
        .empty    (tx_empty[t])
      );
      assign tx_word[t] = {TX_IDS[t*ID_W +: ID_W], tx_head};
    end
  endgenerate

  station_inject #(
    .N(N_TX)
  ) u_inject (
    .req  (~tx_empty),
    .grant(tx_grant),
    .any  (tx_any)
  );

  assign local_take = tx_any && stage_free && !fwd_req;

  always_comb begin
    local_word = '0;
    for (int t = 0; t < N_TX; t++) begin
      if (tx_grant[t]) local_word = local_word | tx_word[t];
    end
  end

  always_comb begin
    if (fwd_take)        stage_src = STG_RING;
    else if (local_take) stage_src = STG_LOCAL;
    else                 stage_src = STG_IDLE;
  end

  // One-entry ring stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v <= 1'b0;
      stg_d <= '0;
    end else if (stage_free) begin
      stg_v <= (stage_src != STG_IDLE);
      case (stage_src)
        STG_RING:  stg_d <= ring_in_data;
        STG_LOCAL: stg_d <= local_word;
        default:   stg_d <= stg_d;
      endcase
    end
  end

  assign ring_out_valid = stg_v;
  assign ring_out_data  = stg_d;
endmodule

// File: rtl/ring_station_chk.sv
module ring_station_chk #(
  parameter int MSG_W = 11,
  parameter int N_TX  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ring_in_valid,
  input logic             ring_in_ready,
  input logic [MSG_W-1:0] ring_in_data,
  input logic             ring_out_valid,
  input logic             ring_out_ready,
  input logic [MSG_W-1:0] ring_out_data,
  input logic             hit,
  input logic             rx_full_sel,
  input logic             fwd_req,
  input logic             local_take,
  input logic [N_TX-1:0]  tx_grant
);
  assert_fwd_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ring_in_valid && ring_in_ready && !hit |=>
      ring_out_valid && ring_out_data == $past(ring_in_data));

  assert_ring_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_req && !ring_out_valid |=> ring_out_data == $past(ring_in_data));

  assert_local_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    local_take |=> ring_out_valid);

  assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ring_in_valid && hit && rx_full_sel |-> !ring_in_ready);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ring_out_valid && !ring_out_ready |=> ring_out_valid && $stable(ring_out_data));

  assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_grant));
endmodule

bind ring_station ring_station_chk #(
  .MSG_W(MSG_W),
  .N_TX (N_TX)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ring_in_valid (ring_in_valid),
  .ring_in_ready (ring_in_ready),
  .ring_in_data  (ring_in_data),
  .ring_out_valid(ring_out_valid),
  .ring_out_ready(ring_out_ready),
  .ring_out_data (ring_out_data),
  .hit           (hit),
  .rx_full_sel   (rx_full_sel),
  .fwd_req       (fwd_req),
  .local_take    (local_take),
  .tx_grant      (tx_grant)
);

// File: tb/ring_station_bench.sv
module ring_station_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 3;
  localparam int PAY_W = 8;
  localparam int MSG_W = ID_W + PAY_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ring_in_valid = 1'b0;
  logic [MSG_W-1:0] ring_in_data = '0;
  logic             ring_in_ready;
  logic             ring_out_valid;
  logic [MSG_W-1:0] ring_out_data;
  logic             ring_out_ready = 1'b1;
  logic [1:0]       tx_enq = '0;
  logic [15:0]      tx_data = '0;
  logic [1:0]       tx_full;
  logic [1:0]       rx_deq = '0;
  logic [15:0]      rx_first;
  logic [1:0]       rx_not_empty;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_station u_ring_station (
    .clk(clk), .rst_n(rst_n),
    .ring_in_valid(ring_in_valid), .ring_in_data(ring_in_data),
    .ring_in_ready(ring_in_ready),
    .ring_out_valid(ring_out_valid), .ring_out_data(ring_out_data),
    .ring_out_ready(ring_out_ready),
    .tx_enq(tx_enq), .tx_data(tx_data), .tx_full(tx_full),
    .rx_deq(rx_deq), .rx_first(rx_first), .rx_not_empty(rx_not_empty)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  // Receiver table restated: tag 5 -> receiver 0, tag 3 -> receiver 1 (R4 packing).
  function automatic int rx_of(input int id);
    if (id == 5) return 0;
    if (id == 3) return 1;
    return -1;
  endfunction

  function automatic logic [MSG_W-1:0] word(input int id, input int p);
    return {3'(id), 8'(p)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) nxt();
    // R1 reset state
    chk(ring_out_valid == 1'b0, "R1 out_valid", 32'(ring_out_valid), 0);
    chk(rx_not_empty == 2'b00, "R1 rx_not_empty", 32'(rx_not_empty), 0);
    chk(tx_full == 2'b00, "R1 tx_full", 32'(tx_full), 0);
    chk(ring_in_ready == 1'b1, "R1 in_ready", 32'(ring_in_ready), 1);
    rst_n = 1'b1;
    nxt();

    // R2/R3/R4 sweep over every tag and several payloads
    for (int id = 0; id < 8; id++) begin
      for (int pi = 0; pi < 4; pi++) begin
        int p;
        int k;
        p = (pi == 0) ? 8'h00 : (pi == 1) ? 8'hA5 : (pi == 2) ? 8'hFF : ((id * 37 + 11) & 8'hFF);
        k = rx_of(id);
        ring_in_valid = 1'b1;
        ring_in_data = word(id, p);
        #1;
        chk(ring_in_ready == 1'b1, "R2 sweep ready", 32'(ring_in_ready), 1);
        nxt();
        ring_in_valid = 1'b0;
        #1;
        if (k < 0) begin
          chk(ring_out_valid && ring_out_data == word(id, p), "R2 forward",
              32'(ring_out_data), 32'(word(id, p)));
        end else begin
          chk(!ring_out_valid, "R3 not forwarded", 32'(ring_out_valid), 0);
          chk(rx_not_empty[k] && rx_first[k*8 +: 8] == 8'(p), "R3 R4 delivered payload",
              32'(rx_first[k*8 +: 8]), 32'(p));
          rx_deq[k] = 1'b1;
          nxt();
          rx_deq = '0;
          #1;
          chk(rx_not_empty == 2'b00, "R3 drained", 32'(rx_not_empty), 0);
        end
        nxt();
      end
    end

    // R5 local send tagged with entry 0 (tag 1), two edges later
    tx_data[7:0] = 8'h3C;
    tx_enq = 2'b01;
    nxt();
    tx_enq = '0;
    #1;
    chk(!ring_out_valid, "R5 not yet", 32'(ring_out_valid), 0);
    nxt();
    #1;
    chk(ring_out_valid && ring_out_data == word(1, 8'h3C), "R5 tagged",
        32'(ring_out_data), 32'(word(1, 8'h3C)));
    nxt();

    // R9 both senders push together: sender 0 first
    tx_data = {8'h66, 8'h44};
    tx_enq = 2'b11;
    nxt();
    tx_enq = '0;
    nxt();
    #1;
    chk(ring_out_data == word(1, 8'h44), "R9 low first", 32'(ring_out_data), 32'(word(1, 8'h44)));
    nxt();
    #1;
    chk(ring_out_valid && ring_out_data == word(6, 8'h66), "R9 then high",
        32'(ring_out_data), 32'(word(6, 8'h66)));
    nxt();
    nxt();

    // R6 ring word beats waiting local word
    tx_data[7:0] = 8'h5A;
    tx_enq = 2'b01;
    nxt();
    tx_enq = '0;
    ring_in_valid = 1'b1;
    ring_in_data = word(0, 8'h77);
    nxt();
    ring_in_valid = 1'b0;
    #1;
    chk(ring_out_data == word(0, 8'h77), "R6 ring first", 32'(ring_out_data), 32'(word(0, 8'h77)));
    nxt();
    #1;
    chk(ring_out_valid && ring_out_data == word(1, 8'h5A), "R6 local after",
        32'(ring_out_data), 32'(word(1, 8'h5A)));
    nxt();
    nxt();

    // R8 downstream stall holds the stage
    ring_out_ready = 1'b0;
    ring_in_valid = 1'b1;
    ring_in_data = word(4, 8'h11);
    nxt();
    ring_in_data = word(7, 8'h22);
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(ring_out_valid && ring_out_data == word(4, 8'h11), "R8 held",
          32'(ring_out_data), 32'(word(4, 8'h11)));
      chk(!ring_in_ready, "R8 input blocked", 32'(ring_in_ready), 0);
      nxt();
    end
    ring_out_ready = 1'b1;
    nxt();
    ring_in_valid = 1'b0;
    #1;
    chk(ring_out_data == word(7, 8'h22), "R8 released", 32'(ring_out_data), 32'(word(7, 8'h22)));
    nxt();
    nxt();

    // R7 full receiver holds ring word, local still injects; R3 order
    ring_in_valid = 1'b1;
    ring_in_data = word(5, 8'h10);
    nxt();
    ring_in_data = word(5, 8'h11);
    nxt();
    ring_in_data = word(5, 8'h12);
    tx_data[15:8] = 8'h99;
    tx_enq = 2'b10;
    #1;
    chk(!ring_in_ready, "R7 blocked", 32'(ring_in_ready), 0);
    nxt();
    tx_enq = '0;
    #1;
    chk(!ring_in_ready, "R7 still blocked", 32'(ring_in_ready), 0);
    nxt();
    #1;
    chk(ring_out_valid && ring_out_data == word(6, 8'h99), "R7 local proceeds",
        32'(ring_out_data), 32'(word(6, 8'h99)));
    chk(rx_first[7:0] == 8'h10, "R3 order 1", 32'(rx_first[7:0]), 32'h10);
    rx_deq = 2'b01;
    nxt();
    rx_deq = '0;
    #1;
    chk(ring_in_ready, "R7 ready after pop", 32'(ring_in_ready), 1);
    nxt();
    ring_in_valid = 1'b0;
    #1;
    chk(rx_first[7:0] == 8'h11, "R3 order 2", 32'(rx_first[7:0]), 32'h11);
    rx_deq = 2'b01;
    nxt();
    #1;
    chk(rx_first[7:0] == 8'h12, "R3 order 3", 32'(rx_first[7:0]), 32'h12);
    nxt();
    rx_deq = '0;
    #1;
    chk(!rx_not_empty[0], "R3 empty", 32'(rx_not_empty), 0);
    nxt();

    // R10 sender queue fills, extra push dropped
    ring_out_ready = 1'b0;
    tx_enq = 2'b01;
    tx_data[7:0] = 8'hA1;
    nxt();
    tx_data[7:0] = 8'hA2;
    nxt();
    tx_data[7:0] = 8'hA3;
    nxt();
    #1;
    chk(tx_full[0], "R10 full", 32'(tx_full), 1);
    tx_data[7:0] = 8'hA4;
    nxt();
    tx_enq = '0;
    ring_out_ready = 1'b1;
    #1;
    chk(ring_out_data == word(1, 8'hA1), "R10 first", 32'(ring_out_data), 32'(word(1, 8'hA1)));
    nxt();
    #1;
    chk(ring_out_data == word(1, 8'hA2), "R10 second", 32'(ring_out_data), 32'(word(1, 8'hA2)));
    nxt();
    #1;
    chk(ring_out_valid && ring_out_data == word(1, 8'hA3), "R10 third",
        32'(ring_out_data), 32'(word(1, 8'hA3)));
    nxt();
    #1;
    chk(!ring_out_valid, "R10 dropped push", 32'(ring_out_valid), 0);
    nxt();

    // R11 pop on empty receiver ignored
    rx_deq = 2'b10;
    nxt();
    rx_deq = '0;
    ring_in_valid = 1'b1;
    ring_in_data = word(3, 8'hC7);
    nxt();
    ring_in_valid = 1'b0;
    #1;
    chk(rx_not_empty[1] && rx_first[15:8] == 8'hC7, "R11 delivery intact",
        32'(rx_first[15:8]), 32'hC7);
    rx_deq = 2'b10;
    nxt();
    rx_deq = '0;
    #1;
    chk(!rx_not_empty[1], "R11 single entry", 32'(rx_not_empty), 0);
    nxt();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule